// File: doc/BRIEF.md
# Subaddressed I2C Register Bridge

This block is an I2C target that turns short framed telegrams into 16-bit register traffic. The incoming telegram carries several things in sequence: the target's device address, one subaddress byte, an optional 16-bit register address, and then either a 16-bit data word or a repeated start for a read. The subaddress byte selects a local control register or one of two external register banks (bank A, bank B), and it also sets the direction. The block oversamples SCL and SDA with the system clock, so it never uses SCL as a clock.

Toward the banks it drives one shared address bus and one shared write-data bus, plus a write strobe and a read strobe for each bank. A bank answers a read strobe by presenting its word in the next cycle. The local control register drives a static reset output that the rest of the chip can hold in reset.

Top module: `i2c_telegram_regif`

## Requirements
- R1: The 2-bit strap `addr_sel_i` picks the device address. 00 and 11 answer write byte 0x80 and read byte 0x81. 01 answers 0x84 and 0x85. 10 answers 0x88 and 0x89. Any other address byte is not acknowledged and no strobe follows.
- R2: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. Data bits are taken on the SCL rise and are returned MSB first, and every 16-bit word goes high byte first.
- R3: The block pulls SDA low during the ninth clock for the matching address and for each accepted byte. A subaddress other than 0x00, 0x10, 0x11, 0x12 or 0x13 is not acknowledged, and the block ignores the bus until the next start.
- R4: Subaddress 0x10 (bank A) or 0x12 (bank B) is followed by a 16-bit address and a 16-bit word. Once the acknowledge of the last data byte ends, the block gives exactly one one-cycle write strobe with that address and data. Bits that a bank does not implement are forced to zero first: with the default parameters bank A keeps all 16 bits and bank B keeps bits 11..0.
- R5: Subaddress 0x11 (bank A) or 0x13 (bank B) is followed by a 16-bit address, a repeated start and the read address byte. The block gives one one-cycle read strobe, takes the word the bank presents in the next cycle, and returns it as two bytes.
- R6: Subaddress 0x00 with two data bytes writes the control register. Only bit 15 is kept, and `reset_o` follows that bit. Subaddress 0x00 followed by a repeated start and the read address returns the kept value, so a write of 0xFFFF reads back as 0x8000.
- R7: After reset, `reset_o` is 0, SDA is released and no strobe is active.
- R8: A stop or an unexpected start before a telegram is complete gives no bank write and no control-register change. A new start restarts decoding from the device address.
- R9: If the master does not acknowledge the first returned byte, the block releases SDA for the rest of the transfer.
- R10: At most one of the four bank strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel_i | input | 2 | Strap selecting the device address |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| reset_o | output | 1 | Static reset from the control register |
| bus_addr_o | output | 16 | Register address toward the banks |
| bus_wdata_o | output | 16 | Masked write data toward the banks |
| a_wr_o | output | 1 | Bank A write strobe |
| a_rd_o | output | 1 | Bank A read strobe |
| a_rdata_i | input | 16 | Bank A read data, valid the cycle after the strobe |
| b_wr_o | output | 1 | Bank B write strobe |
| b_rd_o | output | 1 | Bank B read strobe |
| b_rdata_i | input | 16 | Bank B read data, valid the cycle after the strobe |

## Verification
In one and the same SCL-high window, the bit shifter and the condition detector both act. Before a repeated start, the master raises SCL with SDA high, so one bit has already been shifted in by the time SDA falls. The detector must then take precedence and route the telegram into the read phase instead of corrupting a data byte. The bench provokes this with repeated starts after a control subaddress and after bank read addresses, and it judges the outcome by the word returned. A stop after a single data byte and a fresh start in the middle of a write provoke the abort path, and the bench judges these by the number of write strobes and by the captured address and data.

// File: rtl/i2c_tg_pkg.sv
// Shared types and helpers for the subaddressed I2C register bridge.
// Assumes 8-bit bus bytes and 16-bit register words (two bytes each).
package i2c_tg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // Telegram decode position
    typedef enum logic [3:0] {
        T_IDLE, T_DADDR, T_SUB, T_RA_H, T_RA_L, T_WD_H, T_WD_L,
        T_WCOMMIT, T_RSTART, T_RADDR, T_TX_H, T_TX_L, T_DONE
    } tg_state_t;

    // Target of the current telegram
    typedef enum logic [1:0] {BK_C, BK_A, BK_B} bank_t;

    // 7-bit device address chosen by the strap
    function automatic logic [6:0] dev_of(input logic [1:0] sel);
        case (sel)
            2'b01:   return 7'h42;
            2'b10:   return 7'h44;
            default: return 7'h40;
        endcase
    endfunction

    // States in which the block is shifting in a byte from the master
    function automatic logic is_rx(input tg_state_t s);
        return (s == T_DADDR) || (s == T_SUB) || (s == T_RA_H) || (s == T_RA_L) ||
               (s == T_WD_H) || (s == T_WD_L) || (s == T_RADDR) || (s == T_RSTART);
    endfunction

    // States in which the block is returning a byte to the master
    function automatic logic is_tx(input tg_state_t s);
        return (s == T_TX_H) || (s == T_TX_L);
    endfunction

endpackage

// File: rtl/i2c_tg_sync.sv
// Line conditioner: brings SCL and SDA into the clk domain through a
// flip-flop chain and reports SCL edges plus start and stop conditions.
// Assumes both lines idle high and change far slower than clk.
module i2c_tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;
    logic              scl_s;

    assign scl_s   = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    // Synchronizer chains and one-cycle history of the synchronized levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_lvl;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_c  = scl_s & scl_q & sda_q & ~sda_lvl;
        stop_c   = scl_s & scl_q & ~sda_q & sda_lvl;
    end

endmodule

// File: rtl/i2c_tg_engine.sv
// Telegram engine: bit/byte sequencing, acknowledge, telegram grammar,
// the control register and the bank strobes. Works from the conditioned
// events of i2c_tg_sync. Assumes each bank presents read data in the
// cycle after its read strobe.
module i2c_tg_engine
    import i2c_tg_pkg::*;
#(
    parameter logic [WORD_W-1:0] A_MASK    = 16'hFFFF,
    parameter logic [WORD_W-1:0] B_MASK    = 16'h0FFF,
    parameter logic [WORD_W-1:0] CTRL_MASK = 16'h8000,
    parameter int                RST_BIT   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr_sel_i,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    output logic              sda_oe_o,
    output logic              reset_o,
    output logic [WORD_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    output logic              a_wr_o,
    output logic              a_rd_o,
    input  logic [WORD_W-1:0] a_rdata_i,
    output logic              b_wr_o,
    output logic              b_rd_o,
    input  logic [WORD_W-1:0] b_rdata_i
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] C_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(BYTE_W + 1);

    tg_state_t         st;
    bank_t             bsel;
    logic              rdflag, ackph, mack, rd_pend;
    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] rsh, txsh;
    logic [WORD_W-1:0] addr_q, wdat_q, txword, ctrl_q;
    logic [6:0]        dev;

    assign dev         = dev_of(addr_sel_i);
    assign reset_o     = ctrl_q[RST_BIT];
    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wdat_q & ((bsel == BK_B) ? B_MASK : A_MASK);

    // Bit counting, acknowledge, telegram grammar and bank access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= T_IDLE;
            bsel     <= BK_C;
            rdflag   <= 1'b0;
            ackph    <= 1'b0;
            mack     <= 1'b0;
            rd_pend  <= 1'b0;
            bcnt     <= '0;
            rsh      <= '0;
            txsh     <= '0;
            addr_q   <= '0;
            wdat_q   <= '0;
            txword   <= '0;
            ctrl_q   <= '0;
            sda_oe_o <= 1'b0;
            a_wr_o   <= 1'b0;
            a_rd_o   <= 1'b0;
            b_wr_o   <= 1'b0;
            b_rd_o   <= 1'b0;
        end else begin
            a_wr_o  <= 1'b0;
            a_rd_o  <= 1'b0;
            b_wr_o  <= 1'b0;
            b_rd_o  <= 1'b0;
            rd_pend <= a_rd_o | b_rd_o;
            if (rd_pend) txword <= (bsel == BK_B) ? b_rdata_i : a_rdata_i;

            if (stop_c) begin
                st       <= T_IDLE;
                sda_oe_o <= 1'b0;
                ackph    <= 1'b0;
                bcnt     <= '0;
            end else if (start_c) begin
                sda_oe_o <= 1'b0;
                ackph    <= 1'b0;
                bcnt     <= '0;
                rsh      <= '0;
                if (st == T_RSTART || (st == T_WD_H && bsel == BK_C && bcnt <= 1))
                    st <= T_RADDR;
                else
                    st <= T_DADDR;
            end else if (ackph) begin
                if (scl_fall) begin
                    ackph <= 1'b0;
                    bcnt  <= '0;
                    if (st == T_WCOMMIT) begin
                        st       <= T_DONE;
                        sda_oe_o <= 1'b0;
                        case (bsel)
                            BK_A:    a_wr_o <= 1'b1;
                            BK_B:    b_wr_o <= 1'b1;
                            default: ctrl_q <= wdat_q & CTRL_MASK;
                        endcase
                    end else if (st == T_TX_H) begin
                        txsh     <= txword[WORD_W-1 -: BYTE_W];
                        sda_oe_o <= ~txword[WORD_W-1];
                    end else begin
                        sda_oe_o <= 1'b0;
                    end
                end
            end else if (is_tx(st)) begin
                if (scl_rise) begin
                    if (bcnt < C_FULL) bcnt <= bcnt + 1'b1;
                    else if (bcnt == C_FULL) begin
                        mack <= ~sda_lvl;
                        bcnt <= C_ACK;
                    end
                end else if (scl_fall) begin
                    if (bcnt != 0 && bcnt < C_FULL) begin
                        txsh     <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe_o <= ~txsh[BYTE_W-2];
                    end else if (bcnt == C_FULL) begin
                        sda_oe_o <= 1'b0;
                    end else if (bcnt == C_ACK) begin
                        if (st == T_TX_H && mack) begin
                            st       <= T_TX_L;
                            txsh     <= txword[BYTE_W-1:0];
                            sda_oe_o <= ~txword[BYTE_W-1];
                            bcnt     <= '0;
                        end else begin
                            st       <= T_DONE;
                            sda_oe_o <= 1'b0;
                        end
                    end
                end
            end else if (is_rx(st)) begin
                if (scl_rise && bcnt < C_FULL) begin
                    rsh  <= {rsh[BYTE_W-2:0], sda_lvl};
                    bcnt <= bcnt + 1'b1;
                end else if (scl_fall && bcnt == C_FULL) begin
                    // Accept by default; the cases below fall back to idle
                    ackph    <= 1'b1;
                    sda_oe_o <= 1'b1;
                    case (st)
                        T_DADDR: begin
                            if (rsh == {dev, 1'b0}) st <= T_SUB;
                            else begin
                                st <= T_IDLE; ackph <= 1'b0; sda_oe_o <= 1'b0; bcnt <= '0;
                            end
                        end
                        T_SUB: begin
                            case (rsh)
                                8'h00: begin bsel <= BK_C; rdflag <= 1'b0; st <= T_WD_H; end
                                8'h10: begin bsel <= BK_A; rdflag <= 1'b0; st <= T_RA_H; end
                                8'h11: begin bsel <= BK_A; rdflag <= 1'b1; st <= T_RA_H; end
                                8'h12: begin bsel <= BK_B; rdflag <= 1'b0; st <= T_RA_H; end
                                8'h13: begin bsel <= BK_B; rdflag <= 1'b1; st <= T_RA_H; end
                                default: begin
                                    st <= T_IDLE; ackph <= 1'b0; sda_oe_o <= 1'b0; bcnt <= '0;
                                end
                            endcase
                        end
                        T_RA_H: begin addr_q[WORD_W-1 -: BYTE_W] <= rsh; st <= T_RA_L; end
                        T_RA_L: begin
                            addr_q[BYTE_W-1:0] <= rsh;
                            st <= rdflag ? T_RSTART : T_WD_H;
                        end
                        T_WD_H: begin wdat_q[WORD_W-1 -: BYTE_W] <= rsh; st <= T_WD_L; end
                        T_WD_L: begin wdat_q[BYTE_W-1:0] <= rsh; st <= T_WCOMMIT; end
                        T_RADDR: begin
                            if (rsh == {dev, 1'b1}) begin
                                st <= T_TX_H;
                                case (bsel)
                                    BK_A:    a_rd_o <= 1'b1;
                                    BK_B:    b_rd_o <= 1'b1;
                                    default: txword <= ctrl_q;
                                endcase
                            end else begin
                                st <= T_IDLE; ackph <= 1'b0; sda_oe_o <= 1'b0; bcnt <= '0;
                            end
                        end
                        default: begin
                            st <= T_IDLE; ackph <= 1'b0; sda_oe_o <= 1'b0; bcnt <= '0;
                        end
                    endcase
                end
            end
        end
    end

    // R10: bank strobes never overlap
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_wr_o, a_rd_o, b_wr_o, b_rd_o}));

    // R4: a write strobe lasts one cycle
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_o | b_wr_o) |=> !(a_wr_o | b_wr_o));

    // R4: a write strobe follows the SCL fall that closes the acknowledge
    p_wr_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_o | b_wr_o) |-> $past(scl_fall));

    // R5: a read strobe lasts one cycle
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_o | b_rd_o) |=> !(a_rd_o | b_rd_o));

    // R8: a stop condition releases SDA
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !sda_oe_o);

endmodule

// File: rtl/i2c_telegram_regif.sv
// Top of the subaddressed I2C register bridge: joins the line conditioner
// to the telegram engine. Assumes an external open-drain pad, where
// sda_oe_o high pulls SDA low, and banks that answer one cycle after a read strobe.
module i2c_telegram_regif #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] A_MASK      = 16'hFFFF,
    parameter logic [15:0] B_MASK      = 16'h0FFF,
    parameter logic [15:0] CTRL_MASK   = 16'h8000,
    parameter int          RST_BIT     = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr_sel_i,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    output logic        reset_o,
    output logic [15:0] bus_addr_o,
    output logic [15:0] bus_wdata_o,
    output logic        a_wr_o,
    output logic        a_rd_o,
    input  logic [15:0] a_rdata_i,
    output logic        b_wr_o,
    output logic        b_rd_o,
    input  logic [15:0] b_rdata_i
);
    logic sda_lvl, scl_rise, scl_fall, start_c, stop_c;

    i2c_tg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2c_tg_engine #(
        .A_MASK    (A_MASK),
        .B_MASK    (B_MASK),
        .CTRL_MASK (CTRL_MASK),
        .RST_BIT   (RST_BIT)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_sel_i  (addr_sel_i),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_c     (start_c),
        .stop_c      (stop_c),
        .sda_oe_o    (sda_oe_o),
        .reset_o     (reset_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .a_wr_o      (a_wr_o),
        .a_rd_o      (a_rd_o),
        .a_rdata_i   (a_rdata_i),
        .b_wr_o      (b_wr_o),
        .b_rd_o      (b_rd_o),
        .b_rdata_i   (b_rdata_i)
    );

endmodule

// File: tb/i2c_telegram_regif_test.sv
// Bench: bit-banged I2C master, bank models with registered read data,
// a vector table of telegrams, then directed reset and corner cases.
module i2c_telegram_regif_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe, reset_o, a_wr, a_rd, b_wr, b_rd;
    logic [15:0] bus_addr, bus_wdata;
    logic [15:0] a_rdata = '0, b_rdata = '0;

    assign sda_line = m_sda & ~sda_oe;

    i2c_telegram_regif uut (
        .clk(clk), .rst_n(rst_n), .addr_sel_i(sel), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .reset_o(reset_o), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
        .a_wr_o(a_wr), .a_rd_o(a_rd), .a_rdata_i(a_rdata),
        .b_wr_o(b_wr), .b_rd_o(b_rd), .b_rdata_i(b_rdata)
    );

    function automatic logic [15:0] fn_a(input logic [15:0] a); return a ^ 16'hA5A5; endfunction
    function automatic logic [15:0] fn_b(input logic [15:0] a); return a + 16'h1357; endfunction
    function automatic logic [7:0] devw(input logic [1:0] s);
        return (s == 2'b01) ? 8'h84 : (s == 2'b10) ? 8'h88 : 8'h80;
    endfunction

    // Bank models and strobe monitor
    int          wr_cnt = 0, rd_cnt = 0, multi = 0;
    logic        last_b = 1'b0;
    logic [15:0] last_addr = '0, last_data = '0;
    always @(posedge clk) begin
        if (a_rd) a_rdata <= fn_a(bus_addr);
        if (b_rd) b_rdata <= fn_b(bus_addr);
        if (a_rd | b_rd) rd_cnt <= rd_cnt + 1;
        if (a_wr | b_wr) begin
            wr_cnt <= wr_cnt + 1; last_b <= b_wr; last_addr <= bus_addr; last_data <= bus_wdata;
        end
        if (rst_n && ((a_wr + a_rd + b_wr + b_rd) > 1)) multi <= multi + 1;
    end

    int compared = 0, mismatched = 0;
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic i_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic i_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
        end
        m_sda = 1; wq(); m_scl = 1; wq(); ack = ~sda_line; wq(); m_scl = 0; wq();
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 0; i < 8; i++) begin
            wq(); m_scl = 1; wq(); b = {b[6:0], sda_line}; wq(); m_scl = 0;
        end
        wq(); m_sda = ~give_ack; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); m_sda = 1;
    endtask

    task automatic do_write(input logic [7:0] dev, input logic [7:0] sub, input logic with_addr,
                            input logic [15:0] a, input logic [15:0] d, output logic ok);
        logic k;
        ok = 1;
        i_start();
        send_byte(dev, k); ok &= k;
        send_byte(sub, k); ok &= k;
        if (with_addr) begin send_byte(a[15:8], k); ok &= k; send_byte(a[7:0], k); ok &= k; end
        send_byte(d[15:8], k); ok &= k;
        send_byte(d[7:0], k); ok &= k;
        i_stop();
        wq();
    endtask

    task automatic do_read(input logic [7:0] dev, input logic [7:0] sub, input logic with_addr,
                           input logic [15:0] a, output logic [15:0] v, output logic ok);
        logic k;
        logic [7:0] hi, lo;
        ok = 1;
        i_start();
        send_byte(dev, k); ok &= k;
        send_byte(sub, k); ok &= k;
        if (with_addr) begin send_byte(a[15:8], k); ok &= k; send_byte(a[7:0], k); ok &= k; end
        i_start();
        send_byte(dev | 8'h01, k); ok &= k;
        recv_byte(1'b1, hi);
        recv_byte(1'b0, lo);
        i_stop();
        wq();
        v = {hi, lo};
    endtask

    // sub, address, data
    localparam logic [39:0] VEC [8] = '{
        {8'h10, 16'h0012, 16'hBEEF},
        {8'h12, 16'h0345, 16'h1234},
        {8'h11, 16'h0040, 16'h0000},
        {8'h13, 16'hFFFF, 16'h0000},
        {8'h00, 16'h0000, 16'h8000},
        {8'h00, 16'h0000, 16'h0000},
        {8'h10, 16'hFFFF, 16'h0001},
        {8'h13, 16'h8001, 16'h0000}
    };

    logic done = 1'b0;

    initial begin
        logic ok, k;
        logic [15:0] v;
        logic [7:0]  b;
        int w0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        wq();
        // R7: reset state
        chk("R7 reset_o after reset", reset_o, 0);
        chk("R7 SDA released after reset", sda_oe, 0);
        chk("R7 no strobes after reset", wr_cnt + rd_cnt, 0);

        // Table of telegrams (R2 R3 R4 R5 R6)
        for (int i = 0; i < 8; i++) begin
            logic [7:0]  s;
            logic [15:0] a, d;
            s = VEC[i][39:32]; a = VEC[i][31:16]; d = VEC[i][15:0];
            w0 = wr_cnt; r0 = rd_cnt;
            if (s == 8'h10 || s == 8'h12) begin
                do_write(devw(sel), s, 1'b1, a, d, ok);
                chk("R3 write telegram acked", ok, 1);
                chk("R4 one write strobe", wr_cnt, w0 + 1);
                chk("R4 write bank", last_b, (s == 8'h12));
                chk("R4 write address", last_addr, a);
                chk("R4 write data masked", last_data, (s == 8'h12) ? (d & 16'h0FFF) : d);
            end else if (s == 8'h11 || s == 8'h13) begin
                do_read(devw(sel), s, 1'b1, a, v, ok);
                chk("R3 read telegram acked", ok, 1);
                chk("R5 one read strobe", rd_cnt, r0 + 1);
                chk("R5 R2 returned word", v, (s == 8'h13) ? fn_b(a) : fn_a(a));
            end else begin
                do_write(devw(sel), s, 1'b0, a, d, ok);
                chk("R3 control write acked", ok, 1);
                chk("R6 reset_o follows bit 15", reset_o, d[15]);
            end
        end

        // R6: masking and readback of the control register
        do_write(8'h80, 8'h00, 1'b0, 16'h0, 16'hFFFF, ok);
        chk("R6 reset_o set by 0xFFFF", reset_o, 1);
        do_read(8'h80, 8'h00, 1'b0, 16'h0, v, ok);
        chk("R6 control read acked", ok, 1);
        chk("R6 control readback masked", v, 16'h8000);
        do_write(8'h80, 8'h00, 1'b0, 16'h0, 16'h0000, ok);
        chk("R6 reset_o cleared", reset_o, 0);

        // R1: wrong device address, then each strap value
        w0 = wr_cnt;
        i_start(); send_byte(8'h82, k); i_stop(); wq();
        chk("R1 foreign address not acked", k, 0);
        do_write(8'h84, 8'h10, 1'b1, 16'h0001, 16'h0001, ok);
        chk("R1 0x84 ignored with strap 00", ok, 0);
        chk("R1 no strobe for foreign address", wr_cnt, w0);
        sel = 2'b01; wq();
        do_write(8'h84, 8'h10, 1'b1, 16'h0007, 16'h7777, ok);
        chk("R1 strap 01 answers 0x84", ok, 1);
        chk("R1 strap 01 write landed", last_data, 16'h7777);
        sel = 2'b10; wq();
        do_read(8'h88, 8'h13, 1'b1, 16'h0100, v, ok);
        chk("R1 strap 10 answers 0x88/0x89", ok, 1);
        chk("R1 strap 10 read word", v, fn_b(16'h0100));
        sel = 2'b11; wq();
        do_read(8'h80, 8'h11, 1'b1, 16'h0200, v, ok);
        chk("R1 strap 11 answers 0x80/0x81", ok, 1);
        chk("R1 strap 11 read word", v, fn_a(16'h0200));
        sel = 2'b00; wq();

        // R3: unknown subaddress
        i_start(); send_byte(8'h80, k); send_byte(8'h14, k); i_stop(); wq();
        chk("R3 subaddress 0x14 not acked", k, 0);

        // R8: stop after one data byte, then a start in mid-telegram
        w0 = wr_cnt;
        i_start(); send_byte(8'h80, k); send_byte(8'h10, k);
        send_byte(8'h00, k); send_byte(8'h33, k); send_byte(8'hAA, k); i_stop(); wq();
        chk("R8 stop after partial data gives no write", wr_cnt, w0);
        i_start(); send_byte(8'h80, k); send_byte(8'h12, k);
        send_byte(8'h00, k); send_byte(8'h44, k);
        do_write(8'h80, 8'h10, 1'b1, 16'h0055, 16'hC3C3, ok);
        chk("R8 restarted telegram acked", ok, 1);
        chk("R8 only the complete telegram writes", wr_cnt, w0 + 1);
        chk("R8 address from restarted telegram", last_addr, 16'h0055);
        chk("R8 data from restarted telegram", last_data, 16'hC3C3);
        do_write(8'h80, 8'h00, 1'b0, 16'h0, 16'h8000, ok);
        i_start(); send_byte(8'h80, k); send_byte(8'h00, k); send_byte(8'h00, k); i_stop(); wq();
        chk("R8 partial control write keeps reset_o", reset_o, 1);

        // R9: master refuses the first returned byte
        i_start(); send_byte(8'h80, k); send_byte(8'h11, k);
        send_byte(8'h00, k); send_byte(8'h00, k);
        i_start(); send_byte(8'h81, k);
        recv_byte(1'b0, b);
        chk("R9 first byte still returned", b, 8'hA5);
        recv_byte(1'b0, b);
        chk("R9 SDA released after master nack", b, 8'hFF);
        i_stop(); wq();

        chk("R10 no overlapping strobes", multi, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule